// File: doc/BRIEF.md
# Pitch Count Scoreboard Controller

This block keeps the ball and strike count of a baseball scoreboard from three push buttons: ball, strike and hit. A single free-running system clock samples all three buttons, and no button ever acts as a clock. Each button passes through a two-stage synchronizer and then a counter-based debouncer. A rising-edge detector follows, so a press of any length becomes one event that lasts one cycle.

A control module turns the events into a small set of strobes: clear, add-strike and add-ball. A datapath module updates both count registers in one clocked process from those strobes. The counts appear on two thermometer-coded LED outputs. A fourth ball gives a walk and a third strike gives a strikeout; each clears both counts. A hit also clears both counts. An asynchronous reset clears everything.

Top module: `pitch_scoreboard`

## Requirements
- R1: An active-high asynchronous reset drives `strikeLeds` to 00 and `ballLeds` to 000 at once, with no clock edge needed, and clears all button conditioning state.
- R2: Each accepted strike event moves `strikeLeds` 00 → 01 → 11. Bit 0 lights first.
- R3: Each accepted ball event moves `ballLeds` 000 → 001 → 011 → 111. Bit 0 lights first.
- R4: A ball event while `ballLeds` is 111 clears both outputs to zero (walk).
- R5: A strike event while `strikeLeds` is 11 clears both outputs to zero (strikeout).
- R6: A hit event clears both outputs to zero from any count.
- R7: One press produces exactly one event, however long the button is held. Releasing a button has no effect on the counts.
- R8: A change of button level that lasts fewer than `DEBOUNCE_CYCLES` clocks (default 16) is ignored and leaves both outputs unchanged.
- R9: When events occur in the same cycle, only the highest-priority one acts. The order is hit, then strike, then ball.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rstAsync | input | 1 | Asynchronous reset, active high |
| btnBall | input | 1 | Raw ball button level, active high |
| btnStrike | input | 1 | Raw strike button level, active high |
| btnHit | input | 1 | Raw hit button level, active high |
| strikeLeds | output | 2 | Strike count, thermometer coded |
| ballLeds | output | 3 | Ball count, thermometer coded |

## Verification
The bench aims at the rollover points: the fourth ball and the third strike. A design that wraps only its own counter there would leave the other count standing. It holds a button for many debounce periods and then releases it. A missing edge detector would count again on every cycle, or on the release. Pulses shorter than the debounce window must change nothing, so a debouncer that is too eager shows up as a counted glitch. The bench also presses buttons together. A wrong priority order would then step the wrong count or fail to clear on a hit that lands with another button.

// File: rtl/pitch_pkg.sv
package pitch_pkg;
  typedef struct packed {
    logic clear;
    logic addStrike;
    logic addBall;
  } pitch_cmd_t;

  typedef struct packed {
    logic hit;
    logic strike;
    logic ball;
  } pitch_evt_t;
endpackage

// File: rtl/btn_condition.sv
module btn_condition #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rstAsync,
  input  logic rawLvl,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLvl;
  logic                   stableLvl;
  logic                   prevLvl;
  logic [CNT_W-1:0]       debCnt;

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) syncQ <= '0;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], rawLvl};
  end

  assign syncLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      stableLvl <= 1'b0;
      debCnt    <= '0;
    end else if (syncLvl == stableLvl) begin
      debCnt <= '0;
    end else if (debCnt == CNT_W'(DEBOUNCE_CYCLES - 1)) begin
      stableLvl <= syncLvl;
      debCnt    <= '0;
    end else begin
      debCnt <= debCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) prevLvl <= 1'b0;
    else          prevLvl <= stableLvl;
  end

  assign pressPulse = stableLvl & ~prevLvl;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rstAsync)
    pressPulse |=> !pressPulse); // R7

  AST_DEBOUNCE_FOLLOW: assert property (@(posedge clk) disable iff (rstAsync)
    !$stable(stableLvl) |-> (stableLvl == $past(syncLvl))); // R8
endmodule

// File: rtl/pitch_ctrl.sv
module pitch_ctrl
  import pitch_pkg::*;
(
  input  pitch_evt_t evt,
  input  logic       strikeFull,
  input  logic       ballFull,
  output pitch_cmd_t cmd
);
  always_comb begin
    cmd = '0;
    if (evt.hit) begin
      cmd.clear = 1'b1;
    end else if (evt.strike) begin
      if (strikeFull) cmd.clear     = 1'b1;
      else            cmd.addStrike = 1'b1;
    end else if (evt.ball) begin
      if (ballFull) cmd.clear   = 1'b1;
      else          cmd.addBall = 1'b1;
    end
  end
endmodule

// File: rtl/pitch_dp.sv
module pitch_dp
  import pitch_pkg::*;
#(
  parameter int STRIKE_LEDS = 2,
  parameter int BALL_LEDS   = 3
) (
  input  logic                   clk,
  input  logic                   rstAsync,
  input  pitch_cmd_t             cmd,
  output logic [STRIKE_LEDS-1:0] strikeCnt,
  output logic [BALL_LEDS-1:0]   ballCnt,
  output logic                   strikeFull,
  output logic                   ballFull
);
  always_ff @(posedge clk or posedge rstAsync) begin
    if (rstAsync) begin
      strikeCnt <= '0;
      ballCnt   <= '0;
    end else if (cmd.clear) begin
      strikeCnt <= '0;
      ballCnt   <= '0;
    end else if (cmd.addStrike) begin
      strikeCnt <= {strikeCnt[STRIKE_LEDS-2:0], 1'b1};
    end else if (cmd.addBall) begin
      ballCnt <= {ballCnt[BALL_LEDS-2:0], 1'b1};
    end
  end

  assign strikeFull = strikeCnt[STRIKE_LEDS-1];
  assign ballFull   = ballCnt[BALL_LEDS-1];

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rstAsync)
    $onehot0({cmd.clear, cmd.addStrike, cmd.addBall})); // R9

  AST_STRIKE_THERM: assert property (@(posedge clk) disable iff (rstAsync)
    ((strikeCnt & (strikeCnt + 1'b1)) == '0)); // R2

  AST_BALL_THERM: assert property (@(posedge clk) disable iff (rstAsync)
    ((ballCnt & (ballCnt + 1'b1)) == '0)); // R3
endmodule

// File: rtl/pitch_scoreboard.sv
module pitch_scoreboard
  import pitch_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int STRIKE_LEDS     = 2,
  parameter int BALL_LEDS       = 3
) (
  input  logic                   clk,
  input  logic                   rstAsync,
  input  logic                   btnBall,
  input  logic                   btnStrike,
  input  logic                   btnHit,
  output logic [STRIKE_LEDS-1:0] strikeLeds,
  output logic [BALL_LEDS-1:0]   ballLeds
);
  localparam int NUM_BTNS = 3;

  logic [NUM_BTNS-1:0] rawBtns;
  logic [NUM_BTNS-1:0] pulses;
  pitch_evt_t          evt;
  pitch_cmd_t          cmd;
  logic                strikeFull;
  logic                ballFull;

  assign rawBtns = {btnHit, btnStrike, btnBall};

  for (genvar g = 0; g < NUM_BTNS; g++) begin : g_btn
    btn_condition #(
      .SYNC_STAGES    (SYNC_STAGES),
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) i_cond (
      .clk       (clk),
      .rstAsync  (rstAsync),
      .rawLvl    (rawBtns[g]),
      .pressPulse(pulses[g])
    );
  end

  assign evt = pitch_evt_t'(pulses);

  pitch_ctrl i_ctrl (
    .evt       (evt),
    .strikeFull(strikeFull),
    .ballFull  (ballFull),
    .cmd       (cmd)
  );

  pitch_dp #(
    .STRIKE_LEDS(STRIKE_LEDS),
    .BALL_LEDS  (BALL_LEDS)
  ) i_dp (
    .clk       (clk),
    .rstAsync  (rstAsync),
    .cmd       (cmd),
    .strikeCnt (strikeLeds),
    .ballCnt   (ballLeds),
    .strikeFull(strikeFull),
    .ballFull  (ballFull)
  );

  AST_WALK_CLEARS: assert property (@(posedge clk) disable iff (rstAsync)
    (evt.ball && !evt.strike && !evt.hit && ballLeds[BALL_LEDS-1])
      |=> (ballLeds == '0 && strikeLeds == '0)); // R4

  AST_STRIKEOUT_CLEARS: assert property (@(posedge clk) disable iff (rstAsync)
    (evt.strike && !evt.hit && strikeLeds[STRIKE_LEDS-1])
      |=> (ballLeds == '0 && strikeLeds == '0)); // R5

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (rstAsync)
    evt.hit |=> (ballLeds == '0 && strikeLeds == '0)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rstAsync)
    (pulses == '0) |=> ($stable(ballLeds) && $stable(strikeLeds))); // R7
endmodule

// File: tb/test_pitch_scoreboard.sv
module test_pitch_scoreboard;
  localparam int DEB  = 16;
  localparam int HOLD = DEB + 10;

  logic clk = 1'b0;
  logic rstAsync = 1'b1;
  logic btnBall = 1'b0, btnStrike = 1'b0, btnHit = 1'b0;
  logic [1:0] strikeLeds;
  logic [2:0] ballLeds;

  int nChecks = 0;
  int nFails  = 0;
  int mBalls  = 0;
  int mStrikes = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pitch_scoreboard #(.DEBOUNCE_CYCLES(DEB)) i_pitch_scoreboard (
    .clk(clk), .rstAsync(rstAsync), .btnBall(btnBall), .btnStrike(btnStrike),
    .btnHit(btnHit), .strikeLeds(strikeLeds), .ballLeds(ballLeds));

  function automatic int therm(int n);
    return (1 << n) - 1;
  endfunction

  // mask bit0 ball, bit1 strike, bit2 hit; priority hit, strike, ball
  function automatic void modelApply(logic [2:0] mask);
    if (mask[2]) begin
      mBalls = 0; mStrikes = 0;
    end else if (mask[1]) begin
      if (mStrikes == 2) begin mBalls = 0; mStrikes = 0; end
      else mStrikes++;
    end else if (mask[0]) begin
      if (mBalls == 3) begin mBalls = 0; mStrikes = 0; end
      else mBalls++;
    end
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    chk({tag, " strikes"}, int'(strikeLeds), therm(mStrikes));
    chk({tag, " balls"}, int'(ballLeds), therm(mBalls));
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(logic [2:0] mask, string tag);
    @(negedge clk);
    {btnHit, btnStrike, btnBall} = mask;
    waitCycles(HOLD);
    {btnHit, btnStrike, btnBall} = 3'b000;
    waitCycles(HOLD);
    modelApply(mask);
    checkModel(tag);
  endtask

  initial begin
    void'($urandom(32'd20241127));
    #1;
    chk("R1 reset strikes", int'(strikeLeds), 0);
    chk("R1 reset balls", int'(ballLeds), 0);
    waitCycles(3);
    rstAsync = 1'b0;
    waitCycles(3);

    // R3 ball steps, R4 walk
    press(3'b001, "R3"); press(3'b001, "R3"); press(3'b001, "R3");
    press(3'b010, "R2"); press(3'b010, "R2");
    press(3'b001, "R4");
    // R2 strike steps, R5 strikeout
    press(3'b001, "R3"); press(3'b010, "R2"); press(3'b010, "R2");
    press(3'b010, "R5");
    // R6 hit
    press(3'b001, "R3"); press(3'b010, "R2"); press(3'b100, "R6");

    // R7 long hold counts once, release no effect
    @(negedge clk);
    btnBall = 1'b1;
    waitCycles(6 * DEB);
    modelApply(3'b001);
    checkModel("R7 held");
    btnBall = 1'b0;
    waitCycles(HOLD);
    checkModel("R7 release");

    // R8 short glitches ignored
    btnStrike = 1'b1; waitCycles(3); btnStrike = 1'b0;
    waitCycles(HOLD);
    checkModel("R8 glitch strike");
    btnBall = 1'b1; waitCycles(DEB - 4); btnBall = 1'b0;
    waitCycles(HOLD);
    checkModel("R8 glitch ball");

    // R9 simultaneous presses
    press(3'b011, "R9 strike over ball");
    press(3'b111, "R9 hit over all");
    press(3'b001, "R3"); press(3'b001, "R3");
    press(3'b101, "R9 hit over ball");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [2:0] m;
      m = 3'($urandom_range(1, 7));
      if ($urandom_range(0, 3) != 0) m = (m[0]) ? 3'b001 : ((m[1]) ? 3'b010 : m);
      press(m, "R2 R3 R4 R5 R6 R9 random");
    end

    // R1 async reset mid-count
    press(3'b001, "R3"); press(3'b010, "R2");
    #3 rstAsync = 1'b1;
    #1;
    chk("R1 async strikes", int'(strikeLeds), 0);
    chk("R1 async balls", int'(ballLeds), 0);
    mBalls = 0; mStrikes = 0;
    waitCycles(2);
    rstAsync = 1'b0;
    press(3'b001, "R1 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule